// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Unit

This block holds the interrupt trigger logic for a row of general-purpose input pins. Each pin's level is first passed through a short synchronizer. Its trigger configuration then decides whether the pin reports an event. A pin can trigger on a rising edge, a falling edge, either edge, or a steady high or low level.

When an event occurs while the pin's interrupt is enabled, a sticky interrupt status bit is set. A second sticky bit records wake events that a separate wake-policy block reports. Software clears either bit by pulsing its write-one-to-clear strobe.

A pin asks for service only while its unmask bit is set and at least one of its two status bits is set. All such requests are ORed into one aggregate line for the interrupt controller. Bus decoding, debounce filtering and power-state wake policy live outside this block. Configuration and clear strobes arrive here as ports.

Top module: `gpio_irq_trig`

## Requirements
- R1: After reset every interrupt status, wake status, per-pin pending and aggregate pending output is 0.
- R2: With level_mode=0 and act_sel=2'b00, a 0-to-1 change on the pin sets interrupt status. Status reads 0 two clock edges after the pin changes and reads 1 after the third edge. A 1-to-0 change does not set status.
- R3: With level_mode=0 and act_sel=2'b01, a 1-to-0 pin change sets interrupt status, and a 0-to-1 change does not.
- R4: With level_mode=0 and act_sel=2'b10, both pin transitions set interrupt status.
- R5: With level_mode=1, act_sel=2'b00 triggers while the pin is high and act_sel=2'b01 triggers while it is low. While the pin stays at the active level, status is set again on the cycle after a clear.
- R6: The block never sets status in three unsupported settings: level_mode=1 with act_sel=2'b10, level_mode=1 with act_sel=2'b11, and level_mode=0 with act_sel=2'b11.
- R7: Events set status only while irq_en=1. Dropping irq_en leaves a status bit that is already set unchanged.
- R8: pending_o[i] equals irq_unmask[i] AND (int_sts[i] OR wake_sts[i]). any_pending_o is the OR of all pending_o bits.
- R9: A one-cycle pulse on int_clr clears interrupt status on the next edge. If a trigger event lands on the same edge, status stays 1.
- R10: A pulse on wake_evt sets wake status on the next edge. A pulse on wake_clr clears it, but not if a wake event arrives on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Filtered pin levels (asynchronous) |
| irq_en_i | input | NUM_PINS | Interrupt enable per pin |
| irq_unmask_i | input | NUM_PINS | Interrupt unmask per pin |
| level_mode_i | input | NUM_PINS | 1 = level trigger, 0 = edge trigger |
| act_sel_i | input | NUM_PINS x 2 | 00 high/rising, 01 low/falling, 10 both edges, 11 reserved |
| wake_evt_i | input | NUM_PINS | Wake event pulse from the wake-policy logic |
| int_clr_i | input | NUM_PINS | Write-one-to-clear strobe for interrupt status |
| wake_clr_i | input | NUM_PINS | Write-one-to-clear strobe for wake status |
| int_sts_o | output | NUM_PINS | Sticky interrupt status |
| wake_sts_o | output | NUM_PINS | Sticky wake status |
| pending_o | output | NUM_PINS | Per-pin service request |
| any_pending_o | output | 1 | OR of all pin requests |

## Verification
The hardest case to reach is an edge-mode clear that lands on the very edge where a new transition sets status. Only a single cycle allows this collision, and it sits behind the synchronizer. The bench derives that cycle from the fixed three-edge latency stated in R2. It changes the pin, waits two edges, and then pulses the clear strobe across the third edge.

In level mode the collision happens every cycle while the pin is held active, so that mode exercises the priority in a second way.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    ACT_HIGH = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_BOTH = 2'b10,
    ACT_RSVD = 2'b11
  } act_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     lvl_i,
  input  logic     level_mode_i,
  input  act_sel_e sel_i,
  output logic     evt_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    evt_o = 1'b0;
    if (level_mode_i) begin
      unique case (sel_i)
        ACT_HIGH: evt_o = lvl_i;
        ACT_LOW:  evt_o = ~lvl_i;
        ACT_BOTH: evt_o = 1'b0;  // unsupported in level mode
        ACT_RSVD: evt_o = 1'b0;
      endcase
    end else begin
      unique case (sel_i)
        ACT_HIGH: evt_o = rise;
        ACT_LOW:  evt_o = fall;
        ACT_BOTH: evt_o = rise | fall;
        ACT_RSVD: evt_o = 1'b0;
      endcase
    end
  end

  // R2
  rise_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lvl_i) && !level_mode_i && sel_i == ACT_HIGH) |-> evt_o);

  // R6
  unsupported_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((level_mode_i && sel_i == ACT_BOTH) || sel_i == ACT_RSVD) |-> !evt_o);
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic unmask_i,
  input  logic evt_i,
  input  logic int_clr_i,
  input  logic wake_evt_i,
  input  logic wake_clr_i,
  output logic int_sts_o,
  output logic wake_sts_o,
  output logic pending_o
);
  logic int_set;

  assign int_set = en_i & evt_i;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         int_sts_o <= 1'b0;
    else if (int_set)    int_sts_o <= 1'b1;
    else if (int_clr_i)  int_sts_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wake_sts_o <= 1'b0;
    else if (wake_evt_i)  wake_sts_o <= 1'b1;
    else if (wake_clr_i)  wake_sts_o <= 1'b0;
  end

  assign pending_o = unmask_i & (int_sts_o | wake_sts_o);

  // R9
  set_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i) |=> int_sts_o);

  // R9
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clr_i && !(en_i && evt_i)) |=> !int_sts_o);

  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_sts_o && !int_clr_i) |=> int_sts_o);

  // R7
  no_set_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_sts_o && !en_i) |=> !int_sts_o);

  // R10
  wake_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt_i |=> wake_sts_o);

  // R8
  pending_unmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> unmask_i);
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_PINS-1:0]      pin_i,
  input  logic [NUM_PINS-1:0]      irq_en_i,
  input  logic [NUM_PINS-1:0]      irq_unmask_i,
  input  logic [NUM_PINS-1:0]      level_mode_i,
  input  logic [NUM_PINS-1:0][1:0] act_sel_i,
  input  logic [NUM_PINS-1:0]      wake_evt_i,
  input  logic [NUM_PINS-1:0]      int_clr_i,
  input  logic [NUM_PINS-1:0]      wake_clr_i,
  output logic [NUM_PINS-1:0]      int_sts_o,
  output logic [NUM_PINS-1:0]      wake_sts_o,
  output logic [NUM_PINS-1:0]      pending_o,
  output logic                     any_pending_o
);
  logic [NUM_PINS-1:0] lvl_sync;
  logic [NUM_PINS-1:0] evt;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_i[p]),
      .q_o    (lvl_sync[p])
    );

    gpio_irq_detect u_detect (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lvl_i        (lvl_sync[p]),
      .level_mode_i (level_mode_i[p]),
      .sel_i        (act_sel_e'(act_sel_i[p])),
      .evt_o        (evt[p])
    );

    gpio_irq_status u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (irq_en_i[p]),
      .unmask_i   (irq_unmask_i[p]),
      .evt_i      (evt[p]),
      .int_clr_i  (int_clr_i[p]),
      .wake_evt_i (wake_evt_i[p]),
      .wake_clr_i (wake_clr_i[p]),
      .int_sts_o  (int_sts_o[p]),
      .wake_sts_o (wake_sts_o[p]),
      .pending_o  (pending_o[p])
    );
  end

  assign any_pending_o = |pending_o;

  // R8
  any_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pending_o |-> (pending_o != '0));
endmodule

// File: tb/gpio_irq_trig_tb_top.sv
module gpio_irq_trig_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin = '0, en = '1, um = '1, lvl = '0;
  logic [N-1:0][1:0] sel = '0;
  logic [N-1:0] wevt = '0, iclr = '0, wclr = '0;
  logic [N-1:0] ists, wsts, pend;
  logic anyp;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_trig #(.NUM_PINS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .irq_en_i(en),
    .irq_unmask_i(um), .level_mode_i(lvl), .act_sel_i(sel),
    .wake_evt_i(wevt), .int_clr_i(iclr), .wake_clr_i(wclr),
    .int_sts_o(ists), .wake_sts_o(wsts), .pending_o(pend),
    .any_pending_o(anyp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr0();
    iclr[0] = 1'b1;
    @(negedge clk);
    iclr[0] = 1'b0;
  endtask

  // pin 0 configured, settled and cleared
  task automatic setup0(input logic l, input logic [1:0] s, input logic p);
    lvl[0] = l; sel[0] = s; pin[0] = p; en[0] = 1'b1; um[0] = 1'b1;
    cyc(4);
    clr0();
    cyc(0);
  endtask

  task automatic t_reset();
    check("R1 int_sts", ists, 0);
    check("R1 wake_sts", wsts, 0);
    check("R1 pending", pend, 0);
    check("R1 any_pending", anyp, 0);
  endtask

  task automatic t_rising();
    setup0(1'b0, 2'b00, 1'b0);
    pin[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 latency not yet", ists[0], 0);
    @(negedge clk);
    check("R2 rising sets", ists[0], 1);
    check("R8 pending", pend[0], 1);
    check("R8 any_pending", anyp, 1);
    clr0();
    check("R9 clear", ists[0], 0);
    check("R8 pending cleared", anyp, 0);
    pin[0] = 1'b0;
    cyc(4);
    check("R2 falling ignored", ists[0], 0);
  endtask

  task automatic t_falling();
    setup0(1'b0, 2'b01, 1'b0);
    pin[0] = 1'b1;
    cyc(4);
    check("R3 rising ignored", ists[0], 0);
    pin[0] = 1'b0;
    cyc(4);
    check("R3 falling sets", ists[0], 1);
  endtask

  task automatic t_both();
    setup0(1'b0, 2'b10, 1'b0);
    pin[0] = 1'b1;
    cyc(4);
    check("R4 rising sets", ists[0], 1);
    clr0();
    cyc(2);
    check("R4 cleared", ists[0], 0);
    pin[0] = 1'b0;
    cyc(4);
    check("R4 falling sets", ists[0], 1);
  endtask

  task automatic t_level();
    setup0(1'b1, 2'b00, 1'b0);
    check("R5 high idle", ists[0], 0);
    pin[0] = 1'b1;
    cyc(4);
    check("R5 high sets", ists[0], 1);
    clr0();
    check("R5 reasserts after clear", ists[0], 1);
    clr0(); clr0();
    check("R9 level event beats clear", ists[0], 1);
    setup0(1'b1, 2'b01, 1'b1);
    check("R5 low idle", ists[0], 0);
    pin[0] = 1'b0;
    cyc(4);
    check("R5 low sets", ists[0], 1);
  endtask

  task automatic t_unsupported();
    setup0(1'b1, 2'b10, 1'b0);
    pin[0] = 1'b1; cyc(4); pin[0] = 1'b0; cyc(4);
    check("R6 level+both quiet", ists[0], 0);
    setup0(1'b1, 2'b11, 1'b0);
    pin[0] = 1'b1; cyc(4); pin[0] = 1'b0; cyc(4);
    check("R6 level+rsvd quiet", ists[0], 0);
    setup0(1'b0, 2'b11, 1'b0);
    pin[0] = 1'b1; cyc(4); pin[0] = 1'b0; cyc(4);
    check("R6 edge+rsvd quiet", ists[0], 0);
  endtask

  task automatic t_enable();
    setup0(1'b0, 2'b00, 1'b0);
    en[0] = 1'b0;
    pin[0] = 1'b1;
    cyc(4);
    check("R7 disabled no set", ists[0], 0);
    pin[0] = 1'b0;
    cyc(4);
    en[0] = 1'b1;
    pin[0] = 1'b1;
    cyc(4);
    check("R7 enabled sets", ists[0], 1);
    en[0] = 1'b0;
    cyc(3);
    check("R7 disable keeps status", ists[0], 1);
    um[0] = 1'b0;
    cyc(0);
    check("R8 masked no pending", pend[0], 0);
    check("R8 masked no any", anyp, 0);
    um[0] = 1'b1;
    cyc(0);
    check("R8 unmasked pending", pend[0], 1);
    en[0] = 1'b1;
  endtask

  task automatic t_collide();
    setup0(1'b0, 2'b00, 1'b0);
    pin[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    iclr[0] = 1'b1;
    @(negedge clk);
    iclr[0] = 1'b0;
    check("R9 edge event beats clear", ists[0], 1);
    clr0();
    check("R9 later clear", ists[0], 0);
  endtask

  task automatic t_wake();
    um[1] = 1'b0;
    wevt[1] = 1'b1;
    @(negedge clk);
    wevt[1] = 1'b0;
    check("R10 wake set", wsts[1], 1);
    check("R10 int untouched", ists[1], 0);
    check("R8 wake masked", pend[1], 0);
    um[1] = 1'b1;
    cyc(0);
    check("R8 wake pending", pend[1], 1);
    wevt[1] = 1'b1; wclr[1] = 1'b1;
    @(negedge clk);
    wevt[1] = 1'b0;
    check("R10 wake beats clear", wsts[1], 1);
    @(negedge clk);
    wclr[1] = 1'b0;
    check("R10 wake clear", wsts[1], 0);
    check("R8 pending gone", pend[1], 0);
    check("R2 other pins idle", ists[3:1], 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_rising();
    t_falling();
    t_both();
    t_level();
    t_unsupported();
    t_enable();
    t_collide();
    t_wake();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule